// File: doc/BRIEF.md
# Three-Wire Serial Register Access Master

This block lets on-chip logic read and write single byte-wide registers inside a converter-style peripheral. The peripheral has a three-wire serial port: an active-low select, a serial clock and one shared data line. A request carries a read/write flag, a 13-bit register address and, for writes, one data byte. The master builds the serial frame, shifts it out with a clock produced by a programmable divider, and for reads hands the shared line over to the peripheral and shifts one byte back in.

A write is one unbroken 24-bit frame. A read is a 16-bit header, then a line turnaround signalled by a separate direction output, then eight clocks in which the peripheral drives the line. A mode input selects one of two read forms. In one, select is released between header and data and then asserted again. In the other, select stays asserted across both phases. The shared line appears as separate drive value, drive enable and input signals so that the pad can sit outside the block.

Top module: `tw_spi_master`

## Requirements
- R1: A write sends exactly 24 clock pulses, MSB first. Bit 23 is 0, bits 22:21 are 00, bits 20:8 hold the address and bits 7:0 hold the write byte.
- R2: A read header is exactly 16 clock pulses, MSB first. Bit 15 is 1, bits 14:13 are 00 and bits 12:0 hold the address.
- R3: After the header, a read gives exactly 8 more clock pulses. Each returned bit is sampled while the clock is low, just before its rising edge. Bits are assembled MSB first and the byte appears on `rd_data_o` in the cycle `done_o` is high.
- R4: `cs_n_o` is low at every rising edge of `sclk_o`. It is high whenever the block is idle.
- R5: `sdo_o` only changes while `sclk_o` is low, so it is stable across every high phase.
- R6: Every high phase of `sclk_o` lasts HALF_CYC system cycles. Low phases between pulses last HALF_CYC cycles, or 3×HALF_CYC at the held-select turnaround. `sclk_o` idles low.
- R7: Before the first data-phase rising edge of a read, `dir_in_o`=1 and `sdo_oe_o`=0. Both return to output (`dir_in_o`=0, `sdo_oe_o`=1) only after `cs_n_o` has gone high.
- R8: With `split_cs_i`=1 a read has two select-low periods, with select released between header and data. With `split_cs_i`=0 a read has one. A write always has one.
- R9: When a transaction completes, `sdo_o`=1 and `sdo_oe_o`=1.
- R10: `start_i` is accepted only when `busy_o`=0, and `busy_o` is high the cycle after acceptance. A start pulse during a transaction changes neither the frame in flight nor the number of select periods.
- R11: `done_o` is a one-cycle pulse. `rd_data_o` changes only in a cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 13 | Register address |
| wr_data_i | input | 8 | Byte to write |
| split_cs_i | input | 1 | 1 = release select between read header and data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 8 | Last byte read |
| cs_n_o | output | 1 | Active-low select |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Data line drive value |
| sdo_oe_o | output | 1 | Data line drive enable |
| sdi_i | input | 1 | Data line input value |
| dir_in_o | output | 1 | 1 = data line turned to input |

## Verification
The assertions assume the request inputs matter only in the cycle `start_i` is taken. They also assume `sdi_i` is settled by the end of each low clock phase of the data phase. The peripheral model in the bench meets the second condition by changing its bit only just after a rising edge. It is swept over eight addresses in both read modes, with writes followed by reads of the same registers, plus all-zero and all-one corner frames. One start pulse is issued deliberately mid-transaction with a different address and direction to exercise rejection.

// File: rtl/tw_spi_pkg.sv
package tw_spi_pkg;
    localparam int ADDR_W  = 13;
    localparam int DATA_W  = 8;
    localparam int CNT_W   = 2;
    localparam int HDR_W   = 1 + CNT_W + ADDR_W;
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int BIT_W   = $clog2(FRAME_W + 1);

    // length field: zero means one byte
    localparam logic [CNT_W-1:0] ONE_BYTE = '0;

    typedef enum logic [3:0] {
        PH_IDLE, PH_TX_LO, PH_TX_HI, PH_TURN, PH_REOPEN,
        PH_RX_LO, PH_RX_HI, PH_FIN, PH_REST
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [FRAME_W-1:0] shreg;
        logic [BIT_W-1:0]   bits;
        logic               rd;
        logic               split;
        logic               csn;
        logic               sclk;
        logic               sdo;
        logic               oe;
        logic               dir_in;
        logic               done;
        logic [DATA_W-1:0]  rdata;
    } ctl_t;
endpackage

// File: rtl/tw_spi_halfper.sv
module tw_spi_halfper #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R6

    if (HALF_CYC > 1) begin : g_gap
        AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o); // R6
    end
endmodule

// File: rtl/tw_spi_rxcap.sv
module tw_spi_rxcap #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         cap_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o
);
    logic [W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (clr_i)      data_d = '0;
        else if (cap_i) data_d = {data_q[W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign data_o = data_q;

    AST_CAP_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_i && cap_i)); // R3
endmodule

// File: rtl/tw_spi_master.sv
module tw_spi_master
    import tw_spi_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              split_cs_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    input  logic              sdi_i,
    output logic              dir_in_o
);
    localparam ctl_t CTL_RST = '{
        phase: PH_IDLE, shreg: '0, bits: '0, rd: 1'b0, split: 1'b0,
        csn: 1'b1, sclk: 1'b0, sdo: 1'b1, oe: 1'b1, dir_in: 1'b0,
        done: 1'b0, rdata: '0
    };

    ctl_t d, q;
    logic tick;
    logic accept;
    logic cap;
    logic [DATA_W-1:0] cap_data;
    logic [DATA_W-1:0] tx_low;

    assign accept = start_i && (q.phase == PH_IDLE);
    assign cap    = tick && (q.phase == PH_RX_LO);
    assign tx_low = rd_i ? '0 : wr_data_i;

    tw_spi_halfper #(.HALF_CYC(HALF_CYC)) u_halfper (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (q.phase != PH_IDLE),
        .tick_o (tick)
    );

    tw_spi_rxcap #(.W(DATA_W)) u_rxcap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .cap_i  (cap),
        .bit_i  (sdi_i),
        .data_o (cap_data)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (accept) begin
                    d.phase = PH_TX_LO;
                    d.shreg = {rd_i, ONE_BYTE, addr_i, tx_low};
                    d.bits  = rd_i ? BIT_W'(HDR_W) : BIT_W'(FRAME_W);
                    d.rd    = rd_i;
                    d.split = split_cs_i;
                    d.csn   = 1'b0;
                    d.sdo   = rd_i;
                end
            end
            PH_TX_LO: begin
                if (tick) begin
                    d.sclk  = 1'b1;
                    d.phase = PH_TX_HI;
                end
            end
            PH_TX_HI: begin
                if (tick) begin
                    d.sclk = 1'b0;
                    if (q.bits > BIT_W'(1)) begin
                        d.bits  = q.bits - BIT_W'(1);
                        d.shreg = q.shreg << 1;
                        d.sdo   = q.shreg[FRAME_W-2];
                        d.phase = PH_TX_LO;
                    end else if (q.rd) begin
                        d.csn   = q.split;
                        d.phase = PH_TURN;
                    end else begin
                        d.phase = PH_FIN;
                    end
                end
            end
            PH_TURN: begin
                if (tick) begin
                    d.dir_in = 1'b1;
                    d.oe     = 1'b0;
                    d.phase  = PH_REOPEN;
                end
            end
            PH_REOPEN: begin
                if (tick) begin
                    d.csn   = 1'b0;
                    d.bits  = BIT_W'(DATA_W);
                    d.phase = PH_RX_LO;
                end
            end
            PH_RX_LO: begin
                if (tick) begin
                    d.sclk  = 1'b1;
                    d.phase = PH_RX_HI;
                end
            end
            PH_RX_HI: begin
                if (tick) begin
                    d.sclk = 1'b0;
                    if (q.bits > BIT_W'(1)) begin
                        d.bits  = q.bits - BIT_W'(1);
                        d.phase = PH_RX_LO;
                    end else begin
                        d.phase = PH_FIN;
                    end
                end
            end
            PH_FIN: begin
                if (tick) begin
                    d.csn   = 1'b1;
                    d.sdo   = 1'b1;
                    d.phase = PH_REST;
                end
            end
            PH_REST: begin
                if (tick) begin
                    d.dir_in = 1'b0;
                    d.oe     = 1'b1;
                    d.done   = 1'b1;
                    if (q.rd) d.rdata = cap_data;
                    d.phase  = PH_IDLE;
                end
            end
            default: d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign busy_o    = (q.phase != PH_IDLE);
    assign done_o    = q.done;
    assign rd_data_o = q.rdata;
    assign cs_n_o    = q.csn;
    assign sclk_o    = q.sclk;
    assign sdo_o     = q.sdo;
    assign sdo_oe_o  = q.oe;
    assign dir_in_o  = q.dir_in;

    AST_RISE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> !cs_n_o); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sclk_o && cs_n_o)); // R4
    AST_SDO_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(sdo_o)); // R5
    AST_DIR_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dir_in_o) |-> cs_n_o); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data_o) |-> done_o); // R11
    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R10
endmodule

// File: tb/tw_spi_master_tb.sv
module tw_spi_master_tb;
    localparam int HALF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        start_i = 1'b0, rd_i = 1'b0, split_cs_i = 1'b0;
    logic [12:0] addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic        busy_o, done_o, cs_n_o, sclk_o, sdo_o, sdo_oe_o, dir_in_o, sdi_i;
    logic [7:0]  rd_data_o;

    tw_spi_master #(.HALF_CYC(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
        .addr_i(addr_i), .wr_data_i(wr_data_i), .split_cs_i(split_cs_i),
        .busy_o(busy_o), .done_o(done_o), .rd_data_o(rd_data_o),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
        .sdi_i(sdi_i), .dir_in_o(dir_in_o)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] seed(input int idx);
        return 8'((idx * 29) ^ 8'hA5);
    endfunction

    // peripheral model
    logic        clr_mon = 1'b0;
    int          edge_cnt = 0;
    int          cs_falls = 0;
    int          bad_cs_edge = 0;
    int          bad_dir = 0;
    logic        sl_rd = 1'b0;
    logic [23:0] sl_frame = '0;
    logic [7:0]  sl_byte = '0;
    logic [7:0]  sl_mem [16];
    logic [15:0] sl_wr = '0;

    always @(posedge sclk_o or posedge clr_mon) begin
        if (clr_mon) begin
            edge_cnt = 0;
            sl_rd    = 1'b0;
            sl_frame = '0;
        end else if (cs_n_o) begin
            bad_cs_edge++;
        end else begin
            if (edge_cnt == 0) sl_rd = sdo_o;
            if (sl_rd && edge_cnt >= 16) begin
                if (!(dir_in_o && !sdo_oe_o)) bad_dir++;
            end else begin
                sl_frame = {sl_frame[22:0], sdo_o};
            end
            edge_cnt++;
            if (sl_rd && edge_cnt == 16)
                sl_byte = sl_wr[sl_frame[3:0]] ? sl_mem[sl_frame[3:0]] : seed(int'(sl_frame[3:0]));
            if (!sl_rd && edge_cnt == 24) begin
                sl_mem[sl_frame[11:8]] = sl_frame[7:0];
                sl_wr[sl_frame[11:8]]  = 1'b1;
            end
        end
    end

    always @(negedge cs_n_o or posedge clr_mon) begin
        if (clr_mon) cs_falls = 0;
        else         cs_falls++;
    end

    assign sdi_i = (sl_rd && edge_cnt >= 16 && edge_cnt < 24) ? sl_byte[23 - edge_cnt] : 1'b0;

    // port monitors sampled between edges
    int   hi_run = 0, lo_run = 0;
    int   bad_width = 0, bad_sdo = 0, bad_restore = 0, bad_rdata = 0;
    logic prev_sclk = 1'b0, prev_sdo = 1'b1, prev_dir = 1'b0;
    logic [7:0] prev_rdata = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk_o) begin
                if (!prev_sclk && !(lo_run == HALF || lo_run == 3 * HALF)) bad_width++;
                lo_run = 0;
                hi_run++;
                if (prev_sclk && sdo_o != prev_sdo) bad_sdo++;
            end else begin
                if (prev_sclk && hi_run != HALF) bad_width++;
                hi_run = 0;
                if (!cs_n_o) lo_run++;
                else         lo_run = 0;
            end
            if (prev_dir && !dir_in_o && !cs_n_o) bad_restore++;
            if (rd_data_o != prev_rdata && !done_o) bad_rdata++;
        end
        prev_sclk  = sclk_o;
        prev_sdo   = sdo_o;
        prev_dir   = dir_in_o;
        prev_rdata = rd_data_o;
    end

    logic [7:0] exp_mem [16];

    task automatic run_op(input bit rd, input logic [12:0] a, input logic [7:0] wd,
                          input bit sp, input bit stray);
        int t;
        logic [23:0] exp_frame;
        @(negedge clk);
        clr_mon = 1'b1;
        #1 clr_mon = 1'b0;
        rd_i = rd; addr_i = a; wr_data_i = wd; split_cs_i = sp; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R10", "busy after start", int'(busy_o), 1);
        if (stray) begin
            repeat (10) @(negedge clk);
            rd_i = ~rd; addr_i = ~a; wr_data_i = ~wd; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        t = 0;
        while (!done_o && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(done_o == 1'b1, "R11", "done seen", int'(done_o), 1);
        chk(edge_cnt == 24, rd ? "R3" : "R1", "clock pulses", edge_cnt, 24);
        if (rd) begin
            exp_frame = {8'h00, 1'b1, 2'b00, a};
            chk(sl_frame[15:0] == exp_frame[15:0], "R2", "read header",
                int'(sl_frame[15:0]), int'(exp_frame[15:0]));
            chk(rd_data_o == exp_mem[a[3:0]], "R3", "read byte",
                int'(rd_data_o), int'(exp_mem[a[3:0]]));
            chk(cs_falls == (sp ? 2 : 1), "R8", "select periods (read)", cs_falls, sp ? 2 : 1);
        end else begin
            exp_frame = {1'b0, 2'b00, a, wd};
            chk(sl_frame == exp_frame, stray ? "R10" : "R1", "write frame",
                int'(sl_frame), int'(exp_frame));
            chk(cs_falls == 1, stray ? "R10" : "R8", "select periods (write)", cs_falls, 1);
            exp_mem[a[3:0]] = wd;
        end
        chk(bad_width == 0, "R6", "clock phase widths", bad_width, 0);
        chk(bad_sdo == 0, "R5", "sdo change while clock high", bad_sdo, 0);
        chk(bad_cs_edge == 0, "R4", "rising edge without select", bad_cs_edge, 0);
        chk(bad_dir == 0, "R7", "direction during data phase", bad_dir, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R11", "done one cycle", int'(done_o), 0);
        chk(busy_o == 1'b0, "R10", "idle after done", int'(busy_o), 0);
        chk(sdo_o == 1'b1 && sdo_oe_o == 1'b1, "R9", "idle line high and driven",
            int'({sdo_o, sdo_oe_o}), 3);
        chk(dir_in_o == 1'b0 && cs_n_o == 1'b1, "R7", "direction restored",
            int'({dir_in_o, cs_n_o}), 1);
    endtask

    initial begin
        repeat (200000) @(negedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) exp_mem[i] = seed(i);
        repeat (5) @(negedge clk);
        chk(cs_n_o == 1'b1 && sclk_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0,
            "R4", "reset select and clock", int'({cs_n_o, sclk_o, busy_o, done_o}), 8);
        chk(sdo_o == 1'b1 && sdo_oe_o == 1'b1 && dir_in_o == 1'b0 && rd_data_o == 8'h00,
            "R9", "reset line state", int'({sdo_o, sdo_oe_o, dir_in_o}), 6);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int sp = 0; sp < 2; sp++) begin
            for (int k = 0; k < 8; k++) begin
                logic [12:0] a;
                a = 13'((k + 8 * sp) * 1171) ^ 13'(k << 9);
                run_op(1'b1, a, 8'h00, sp[0], 1'b0);
                run_op(1'b0, a, 8'((k * 37 + sp * 101) ^ 8'h5A), sp[0], 1'b0);
                run_op(1'b1, a, 8'h00, sp[0], 1'b0);
            end
        end
        for (int sp = 0; sp < 2; sp++) begin
            run_op(1'b0, 13'h0000, 8'h00, sp[0], 1'b0);
            run_op(1'b1, 13'h0000, 8'h00, sp[0], 1'b0);
            run_op(1'b0, 13'h1FFF, 8'hFF, sp[0], 1'b0);
            run_op(1'b1, 13'h1FFF, 8'h00, sp[0], 1'b0);
        end
        run_op(1'b0, 13'h0A5C, 8'h3C, 1'b0, 1'b1);
        run_op(1'b1, 13'h0A5C, 8'h00, 1'b1, 1'b0);

        chk(bad_rdata == 0, "R11", "read byte changed without done", bad_rdata, 0);
        chk(bad_restore == 0, "R7", "direction restored under select", bad_restore, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule